// File: doc/BRIEF.md
# Fractional UART Baud Generator

This block makes the timing strobes for a UART that oversamples each bit sixteen times. It divides the peripheral clock by a ratio that can be set in quarter-clock steps. The ratio is written as a fixed-point value in a divider register. The register has two fractional bits. The six lowest bits of the register are ignored. A divider field of N gives a ratio of (4 + N) / 4 clocks per oversample tick. The baud rate is therefore 4·f_clk / (16·(4 + N)). A field of zero gives one tick on every clock.

Inside, a phase accumulator adds 4 on each clock. When the accumulator reaches 4 + N, it raises a one-cycle sample strobe and keeps the remainder, so a fractional ratio averages out exactly. A modulo-16 counter of sample strobes raises the bit strobe together with every sixteenth sample strobe. The transmitter or receiver pulses the restart input when it starts a frame, and a write to the divider has the same effect. Either one clears the accumulator, the counter and both strobes, so that timing begins again from a known phase.

Top module: `uart_frac_baud`

## Requirements
- R1: Reset clears `sample_tick`, `bit_tick` and the divider field, so `rd_data` reads 0.
- R2: A write with `wr_addr` equal to `DIV_ADDR` (default 0x14) stores `wr_data[20:6]` as the 15-bit divider field N. From the next cycle `rd_data` returns N in bits [20:6] and zero in every other bit.
- R3: A write to any other address changes neither the divider nor the phase. `rd_data` and the running strobe pattern continue as before.
- R4: After the phase is cleared, exactly floor(4·C / (4 + N)) sample strobes occur in the following C clock cycles. This holds for integer and fractional ratios, so 1000 strobes take 250·(4 + N) cycles.
- R5: With N ≥ 4 (a ratio of at least 2), `sample_tick` is never high on two consecutive cycles unless the phase is cleared in between.
- R6: `bit_tick` pulses only together with `sample_tick`, once for every 16 sample strobes counted from a phase clear.
- R7: A `restart` pulse clears both strobes in the following cycle. The first sample strobe then comes ceil((4 + N) / 4) cycles after the restart edge.
- R8: A divider write clears the phase in the same way as `restart`, and the new ratio applies to the first strobe after it.
- R9: The largest field, N = 32767, gives its first sample strobe 8193 cycles after the phase clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | DATA_W | Write data |
| restart | input | 1 | Frame-start pulse that clears the phase |
| rd_data | output | DATA_W | Current divider register value |
| sample_tick | output | 1 | One-cycle oversample strobe |
| bit_tick | output | 1 | Strobe on every 16th sample strobe |

## Verification
The hardest condition to reach is the top of the divider range. A very slow ratio is rarely reached in normal use, and its first strobe comes more than eight thousand cycles after a clear. The bench writes all ones to the register, which sets the field to its maximum. It then counts cycles from that write and checks that no strobe appears before cycle 8193 and that one appears at cycle 8193. Fractional ratios are checked by exact strobe counts over windows of 1000 ticks. These counts would not come out right if the remainder were dropped on each wrap.

// File: rtl/uart_frac_baud.sv
module uart_frac_baud #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int DIV_LSB = 6,
  parameter int DIV_W   = 15,
  parameter int OSR     = 16,
  parameter logic [ADDR_W-1:0] DIV_ADDR = 8'h14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              restart,
  output logic [DATA_W-1:0] rd_data,
  output logic              sample_tick,
  output logic              bit_tick
);
  localparam int ACC_W = DIV_W + 2;
  localparam int CNT_W = $clog2(OSR);

  logic [DIV_W-1:0] div_q;
  logic [ACC_W-1:0] acc_q;
  logic [CNT_W-1:0] cnt_q;

  wire load  = wr_en && (wr_addr == DIV_ADDR);
  wire clear = load || restart;
  wire [ACC_W-1:0] step = acc_q + ACC_W'(4);
  wire [ACC_W-1:0] span = ACC_W'(div_q) + ACC_W'(4);
  wire hit  = step >= span;
  wire wrap = cnt_q == CNT_W'(OSR - 1);
  wire unused_wr_bits = ^{wr_data[DATA_W-1:DIV_LSB+DIV_W], wr_data[DIV_LSB-1:0]};

  assign rd_data = DATA_W'({div_q, {DIV_LSB{1'b0}}});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q       <= '0;
      acc_q       <= '0;
      cnt_q       <= '0;
      sample_tick <= 1'b0;
      bit_tick    <= 1'b0;
    end else begin
      if (load) div_q <= wr_data[DIV_LSB +: DIV_W];
      if (clear) begin
        acc_q       <= '0;
        cnt_q       <= '0;
        sample_tick <= 1'b0;
        bit_tick    <= 1'b0;
      end else begin
        acc_q       <= hit ? step - span : step;
        sample_tick <= hit;
        bit_tick    <= hit && wrap;
        if (hit) cnt_q <= wrap ? '0 : cnt_q + CNT_W'(1);
      end
    end
  end

  p_bit_with_sample_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> sample_tick);

  p_clear_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (restart || load) |=> (!sample_tick && !bit_tick));

  p_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_tick && div_q >= DIV_W'(4) && !clear) |=> !sample_tick);

  p_other_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !load) |=> $stable(rd_data));

endmodule

// File: tb/uart_frac_baud_test.sv
module uart_frac_baud_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        restart = 1'b0;
  logic [31:0] rd_data;
  logic        sample_tick, bit_tick;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  localparam int NVEC = 7;
  localparam int VEC_DIV [NVEC] = '{0, 1, 2, 3, 4, 13, 100};

  always #2.5 clk = ~clk;

  uart_frac_baud uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .restart(restart), .rd_data(rd_data),
    .sample_tick(sample_tick), .bit_tick(bit_tick)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic check(string req, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic reg_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_restart();
    @(negedge clk);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
  endtask

  task automatic count(int c, output int ts, output int bs);
    ts = 0; bs = 0;
    for (int k = 0; k < c; k++) begin
      @(negedge clk);
      if (sample_tick) ts++;
      if (bit_tick) begin
        bs++;
        if (!sample_tick) check("R6 bit without sample", 0, 1);
      end
    end
  endtask

  initial begin
    int ts, bs, first;
    repeat (3) @(negedge clk);
    check("R1 sample_tick", sample_tick, 0);
    check("R1 bit_tick", bit_tick, 0);
    check("R1 rd_data", rd_data, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      reg_write(8'h14, 32'(VEC_DIV[i]) << 6);
      check("R2 rd_data", rd_data, 32'(VEC_DIV[i]) << 6);
      count(250 * (VEC_DIV[i] + 4), ts, bs);
      check("R4 ticks per 1000 window", ts, 1000);
      check("R6 bit ticks", bs, 1000 / 16);
    end

    reg_write(8'h14, 32'h0000_0013);
    check("R2 low bits dropped", rd_data, 0);
    count(3, ts, bs);
    reg_write(8'h10, 32'h0000_1000);
    check("R3 rd_data unchanged", rd_data, 0);
    check("R3 phase not cleared", sample_tick, 1);

    reg_write(8'h14, 32'd7 << 6);
    count(50, ts, bs);
    pulse_restart();
    check("R7 strobe cleared", sample_tick, 0);
    first = 0;
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      if (sample_tick && first == 0) first = k;
    end
    check("R7 first tick cycle", first, 3);
    pulse_restart();
    count(110, ts, bs);
    check("R7 ticks after restart", ts, 40);
    check("R6 bits after restart", bs, 2);

    reg_write(8'h14, 32'd1 << 6);
    count(7, ts, bs);
    check("R8 ticks after write", ts, 5);

    reg_write(8'h14, 32'hFFFF_FFFF);
    check("R9 rd_data max", rd_data, 32'h001F_FFC0);
    count(8192, ts, bs);
    check("R9 no tick before 8193", ts, 0);
    @(negedge clk);
    check("R9 tick at 8193", sample_tick, 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule